// File: doc/BRIEF.md
# Program Cycle Status Poller

This block runs the timed erase-and-program phase of a flash-style byte memory and reports its progress through the normal read path. A load stage hands it bytes one at a time. Each byte is kept in a sector-wide page latch, and its byte offset selects the slot. A start pulse then opens a busy window of a fixed number of clock cycles. At the end of that window the latched sector is written into a small behavioural array.

While the window is open, reads do not return array contents. They return a status byte instead. Software can watch either of two signals to detect completion. The first is the inverse of bit 7 of the most recently loaded byte. The second is a bit 6 that changes value after each finished read. Once the window closes, reads return true array data. Output drive follows the chip-enable, output-enable and write-enable controls, which are all active low.

Top module: `prog_poll_top`

## Requirements
- R1: After reset the block is idle. `busy` and `done` are low, every array byte reads 8'hFF, the page latch is empty and the sector register is 0.
- R2: `dataOe` is high exactly when `ceN`=0, `oeN`=0 and `weN`=1. Whenever `dataOe` is low, `dataOut` is 8'h00.
- R3: A `startReq` sampled while idle raises `busy` on the next cycle. `busy` then stays high for exactly CYCLE_LEN cycles. `done` is high for the one cycle right after `busy` falls.
- R4: While `busy` is high, a read at any address returns bit 7 equal to the inverse of bit 7 of the most recently accepted load.
- R5: While `busy` is high, bits 5:0 of a read are 0. Bit 6 is cleared when a cycle starts. It inverts once per finished read strobe (enable high in one cycle, low in the next), however many clocks the read lasted, and it never changes on clocks alone.
- R6: On completion, each loaded byte is written to the array at {sector, offset}. The sector is `loadAddr[ADDR_W-1:SECTOR_W]` of the last accepted load and the offset is `loadAddr[SECTOR_W-1:0]`. Other sectors are unchanged, and idle reads return array data.
- R7: Bytes of the programmed sector whose offsets were not loaded since the previous commit read 8'hFF afterwards.
- R8: Loads and start requests that arrive while `busy` is high are ignored. They do not alter the latch, the last loaded byte, the sector or the cycle length.
- R9: Bytes may be loaded in any order. A repeated offset keeps the data of its last load, and a load and a start in the same idle cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadReq | input | 1 | Byte load strobe from the load stage |
| loadAddr | input | ADDR_W | Address of the byte being loaded |
| loadData | input | 8 | Byte being loaded |
| startReq | input | 1 | Start pulse for the program cycle |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| rdAddr | input | ADDR_W | Read address |
| dataOut | output | 8 | Read data or status byte |
| dataOe | output | 1 | Output drive enable (low means high impedance) |
| busy | output | 1 | Program cycle in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two cycles are run. In the first, the last loaded byte has bit 7 clear. In the second, it has bit 7 set. Together they separate a true inversion from a constant bit 7 on the status byte.

Polling uses reads of one clock and of several clocks, separated by gaps of varying length. This distinguishes a toggle that advances per finished read from one that advances per clock or per read start. Chip-enable and output-enable are also switched in mixed combinations.

The programmed sector is loaded out of order, with one offset written twice and some offsets left empty. Extra loads and starts are sent during busy. A new load and start are issued right after completion. Each of these separates correct latch handling from stale or leaking state.

// File: rtl/prog_poll_pkg.sv
package prog_poll_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;     // accept the presented byte into the page latch
    logic commitEn;   // write the page latch into the array this cycle
    logic statusSel;  // read path returns status instead of array data
    logic toggleBit;  // current value of the read-toggle status bit
  } pollStrobe_t;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/prog_poll_ctrl.sv
module prog_poll_ctrl
  import prog_poll_pkg::*;
#(
  parameter int CYCLE_LEN = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadReq,
  input  logic        startReq,
  input  logic        readEn,
  output pollStrobe_t strobes,
  output logic        busy,
  output logic        done
);

  localparam int CNT_W = (CYCLE_LEN > 1) ? $clog2(CYCLE_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLE_LEN - 1);

  typedef enum logic [0:0] {ST_IDLE, ST_BUSY} pollState_t;

  pollState_t     state;
  logic [CNT_W-1:0] cnt;
  logic           doneQ;
  logic           toggleQ;
  logic           readPrev;
  logic           readEnd;

  assign readEnd = readPrev && !readEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      doneQ    <= 1'b0;
      toggleQ  <= 1'b0;
      readPrev <= 1'b0;
    end else begin
      readPrev <= readEn;
      doneQ    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state   <= ST_BUSY;
            cnt     <= CNT_LAST;
            toggleQ <= 1'b0;
          end
        end
        ST_BUSY: begin
          if (readEnd) toggleQ <= ~toggleQ;
          if (cnt == '0) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.loadEn    = loadReq && (state == ST_IDLE);
    strobes.commitEn  = (state == ST_BUSY) && (cnt == '0);
    strobes.statusSel = (state == ST_BUSY);
    strobes.toggleBit = toggleQ;
  end

  assign busy = (state == ST_BUSY);
  assign done = doneQ;

  AST_DONE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_LAST); // R3
  AST_TOGGLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !readEnd) |=> $stable(toggleQ)); // R5
  AST_START_CLEARS_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !toggleQ); // R5

endmodule

// File: rtl/prog_poll_datapath.sv
module prog_poll_datapath
  import prog_poll_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int SECTOR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobe_t       strobes,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              readEn,
  output logic [7:0]        dataOut
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int SECTOR_LEN = 1 << SECTOR_W;
  localparam int SEC_IDX_W  = ADDR_W - SECTOR_W;

  logic [7:0]           memRow [DEPTH];
  logic [7:0]           slotData [SECTOR_LEN];
  logic [SECTOR_LEN-1:0] latchMask;
  logic [SEC_IDX_W-1:0] secIdx;
  logic [7:0]           lastData;
  logic [SECTOR_W-1:0]  loadOff;
  logic [7:0]           readVal;

  assign loadOff = loadAddr[SECTOR_W-1:0];

  // Sector index and last loaded byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secIdx   <= '0;
      lastData <= '0;
    end else if (strobes.loadEn) begin
      secIdx   <= loadAddr[ADDR_W-1:SECTOR_W];
      lastData <= loadData;
    end
  end

  // Page latch slots
  for (genvar s = 0; s < SECTOR_LEN; s++) begin : gSlot
    logic [7:0] slotQ;
    logic       validQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotQ  <= ERASED_BYTE;
        validQ <= 1'b0;
      end else if (strobes.commitEn) begin
        validQ <= 1'b0;
      end else if (strobes.loadEn && (loadOff == SECTOR_W'(s))) begin
        slotQ  <= loadData;
        validQ <= 1'b1;
      end
    end
    assign slotData[s]  = slotQ;
    assign latchMask[s] = validQ;
  end

  // Behavioural array rows
  for (genvar r = 0; r < DEPTH; r++) begin : gRow
    localparam logic [SEC_IDX_W-1:0] ROW_SEC = SEC_IDX_W'(r >> SECTOR_W);
    localparam int ROW_OFF = r % SECTOR_LEN;
    logic [7:0] rowQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rowQ <= ERASED_BYTE;
      end else if (strobes.commitEn && (secIdx == ROW_SEC)) begin
        rowQ <= latchMask[ROW_OFF] ? slotData[ROW_OFF] : ERASED_BYTE;
      end
    end
    assign memRow[r] = rowQ;
  end

  // Read path: status while programming, array data otherwise
  always_comb begin
    if (strobes.statusSel)
      readVal = {~lastData[7], strobes.toggleBit, 6'b000000};
    else
      readVal = memRow[rdAddr];
    dataOut = readEn ? readVal : 8'h00;
  end

  AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.statusSel && !strobes.commitEn) |=>
      ($stable(latchMask) && $stable(lastData) && $stable(secIdx))); // R8
  AST_COMMIT_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitEn |=> (latchMask == '0)); // R6

endmodule

// File: rtl/prog_poll_top.sv
module prog_poll_top
  import prog_poll_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int SECTOR_W  = 3,
  parameter int CYCLE_LEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadReq,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  input  logic              startReq,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  output logic              busy,
  output logic              done
);

  pollStrobe_t strobes;
  logic        readEn;

  assign readEn = !ceN && !oeN && weN;
  assign dataOe = readEn;

  prog_poll_ctrl #(.CYCLE_LEN(CYCLE_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .loadReq(loadReq), .startReq(startReq),
    .readEn(readEn), .strobes(strobes), .busy(busy), .done(done)
  );

  prog_poll_datapath #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadAddr(loadAddr),
    .loadData(loadData), .rdAddr(rdAddr), .readEn(readEn), .dataOut(dataOut)
  );

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == 8'h00)); // R2
  AST_STATUS_LOW_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dataOe) |-> (dataOut[5:0] == 6'b000000)); // R5
  AST_BUSY_HOLDS_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> busy); // R3

endmodule

// File: tb/prog_poll_top_tb_top.sv
`timescale 1ns/1ps
module prog_poll_top_tb_top;

  localparam int ADDR_W = 6;
  localparam int SECTOR_W = 3;
  localparam int CYC = 24;
  localparam int WATCHDOG_NS = 4 * 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadReq = 1'b0;
  logic [ADDR_W-1:0] loadAddr = '0;
  logic [7:0] loadData = '0;
  logic startReq = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0] dataOut;
  logic dataOe, busy, done;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  bit cmpOn = 0;

  always #2 clk = ~clk;

  prog_poll_top #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .CYCLE_LEN(CYC)) dut_i (
    .clk(clk), .rstN(rstN), .loadReq(loadReq), .loadAddr(loadAddr),
    .loadData(loadData), .startReq(startReq), .ceN(ceN), .oeN(oeN), .weN(weN),
    .rdAddr(rdAddr), .dataOut(dataOut), .dataOe(dataOe), .busy(busy), .done(done)
  );

  // Behavioural reference model
  logic [7:0] mArr [64];
  logic [7:0] mLatch [8];
  logic [7:0] mMask;
  int mSec, mCnt;
  logic mBusy, mDone, mTog, mPrevRd;
  logic [7:0] mLast;

  always @(posedge clk or negedge rstN) begin
    logic rdNow;
    if (!rstN) begin
      for (int i = 0; i < 64; i++) mArr[i] <= 8'hFF;
      for (int i = 0; i < 8; i++) mLatch[i] <= 8'hFF;
      mMask <= '0; mSec <= 0; mCnt <= 0;
      mBusy <= 0; mDone <= 0; mTog <= 0; mPrevRd <= 0; mLast <= '0;
    end else begin
      rdNow = !ceN && !oeN && weN;
      if (mBusy) begin
        if (mPrevRd && !rdNow) mTog <= !mTog;
        if (mCnt == 0) begin
          for (int i = 0; i < 8; i++)
            mArr[mSec*8+i] <= mMask[i] ? mLatch[i] : 8'hFF;
          mMask <= '0; mBusy <= 0; mDone <= 1;
        end else begin
          mCnt <= mCnt - 1; mDone <= 0;
        end
      end else begin
        mDone <= 0;
        if (loadReq) begin
          mLatch[loadAddr[2:0]] <= loadData;
          mMask[loadAddr[2:0]] <= 1'b1;
          mSec <= int'(loadAddr[5:3]);
          mLast <= loadData;
        end
        if (startReq) begin
          mBusy <= 1; mCnt <= CYC - 1; mTog <= 0;
        end
      end
      mPrevRd <= rdNow;
    end
  end

  function automatic logic [7:0] expOut();
    if (!(!ceN && !oeN && weN)) return 8'h00;
    if (mBusy) return {~mLast[7], mTog, 6'b000000};
    return mArr[rdAddr];
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (cmpOn && !finished) begin
      check("R2 dataOe", {7'd0, dataOe}, {7'd0, (!ceN && !oeN && weN)});
      check("R3 R8 busy", {7'd0, busy}, {7'd0, mBusy});
      check("R3 done", {7'd0, done}, {7'd0, mDone});
      if (!(!ceN && !oeN && weN)) check("R2 dataOut", dataOut, expOut());
      else if (mBusy) check("R4 R5 status", dataOut, expOut());
      else check("R6 R7 R9 data", dataOut, expOut());
    end
  end

  task automatic drive(input logic ld, input logic [5:0] la, input logic [7:0] dd,
                       input logic st, input logic c, input logic o, input logic w,
                       input logic [5:0] ra);
    @(negedge clk);
    loadReq = ld; loadAddr = la; loadData = dd; startReq = st;
    ceN = c; oeN = o; weN = w; rdAddr = ra;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 1, 1, 1, 0);
  endtask

  task automatic loadByte(input logic [5:0] a, input logic [7:0] d);
    drive(1, a, d, 0, 1, 1, 1, 0);
  endtask

  task automatic readCheck(input logic [5:0] a, input logic [7:0] exp, input string tag);
    drive(0, 0, 0, 0, 0, 0, 1, a);
    #1;
    check(tag, dataOut, exp);
    drive(0, 0, 0, 0, 1, 1, 1, 0);
  endtask

  task automatic pollRead(input logic [5:0] a, input int len);
    for (int i = 0; i < len; i++) drive(0, 0, 0, 0, 0, 0, 1, a);
  endtask

  initial begin
    #(WATCHDOG_NS);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cmpOn = 1;
    #1;
    // R1: reset state
    check("R1 busy", {7'd0, busy}, 8'd0);
    check("R1 done", {7'd0, done}, 8'd0);
    check("R1 dataOut", dataOut, 8'h00);
    readCheck(6'd5, 8'hFF, "R1 erased");
    readCheck(6'd40, 8'hFF, "R1 erased");

    // R2: enable combinations
    drive(0, 0, 0, 0, 0, 1, 1, 6'd5);
    drive(0, 0, 0, 0, 1, 0, 1, 6'd5);
    drive(0, 0, 0, 0, 0, 0, 0, 6'd5);
    quiet(1);

    // First cycle, sector 2, out of order, offset repeated (R9)
    loadByte(6'd19, 8'hA5);
    loadByte(6'd16, 8'h3C);
    loadByte(6'd19, 8'h96);
    loadByte(6'd21, 8'h0F);
    drive(0, 0, 0, 1, 1, 1, 1, 0);
    // busy: polls of different lengths, ignored loads/starts (R8)
    pollRead(6'd21, 1);
    quiet(2);
    pollRead(6'd3, 4);
    drive(1, 6'd22, 8'h55, 0, 1, 1, 1, 0);
    drive(0, 0, 0, 1, 1, 1, 1, 0);
    drive(1, 6'd50, 8'h80, 1, 0, 1, 1, 6'd21);
    pollRead(6'd21, 2);
    quiet(1);
    pollRead(6'd0, 1);
    pollRead(6'd0, 1);
    drive(0, 0, 0, 0, 0, 1, 1, 0);
    pollRead(6'd21, 3);
    quiet(12);

    // After completion
    readCheck(6'd19, 8'h96, "R9 repeated offset");
    readCheck(6'd16, 8'h3C, "R6 loaded");
    readCheck(6'd21, 8'h0F, "R6 loaded");
    readCheck(6'd22, 8'hFF, "R8 R7 ignored load");
    readCheck(6'd50, 8'hFF, "R8 ignored load");
    readCheck(6'd17, 8'hFF, "R7 unloaded");
    readCheck(6'd8, 8'hFF, "R6 other sector");

    // Second cycle, sector 7, load together with start (R9), bit 7 set
    loadByte(6'd60, 8'h81);
    drive(1, 6'd63, 8'hEE, 1, 1, 1, 1, 0);
    for (int k = 0; k < 8; k++) begin
      pollRead(6'd63, 1 + (k % 3));
      quiet(k % 2);
    end
    quiet(14);
    // New cycle right after completion
    drive(1, 6'd0, 8'h12, 1, 1, 1, 1, 0);
    quiet(2);
    pollRead(6'd0, 2);
    quiet(CYC + 2);

    readCheck(6'd60, 8'h81, "R6 loaded");
    readCheck(6'd63, 8'hEE, "R9 load with start");
    readCheck(6'd62, 8'hFF, "R7 unloaded");
    readCheck(6'd0, 8'h12, "R6 back to back");
    readCheck(6'd1, 8'hFF, "R7 unloaded");
    readCheck(6'd19, 8'h96, "R6 untouched sector");
    quiet(2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule